// File: doc/BRIEF.md
# Line-Buffered VGA Display Controller

This block produces raster timing for a 640x480 display and paints each visible line from a small on-chip buffer. The buffer holds a single scan line. A host processor keeps it filled. At the end of every visible line the block raises an interrupt. The host answers by writing the pixels of the next row through a 32-bit write port, then acknowledges. The refill must finish before the next line's active region starts.

Pixels are one byte each in 3-3-2 colour form: red in the top three bits, green in the next three and blue in the bottom two. Each field is most significant bit first. The block widens every channel to four bits by repeating its high bits. It forces all colour outputs to zero outside the visible window. A line-number output tells the host which row is being scanned, so it can work out which row to fetch. Every timing figure is a parameter. The defaults give the usual 800x525 frame at a 25 MHz pixel rate, with both syncs active low.

Top module: `vga_line_display`

## Requirements
- R1: While reset is held, `irq` is 0, `hsync_n` and `vsync_n` are 1, all colour outputs are 0 and `line_num` is 0.
- R2: The column counter runs from 0 to H_VIS+H_FP+H_SYNC+H_BP-1 and then returns to 0. `line_num` advances by one on each column wrap and returns to 0 after line V_VIS+V_FP+V_SYNC+V_BP-1.
- R3: `hsync_n` is 0 exactly for columns H_VIS+H_FP through H_VIS+H_FP+H_SYNC-1. Like the colour outputs, it appears two clocks after the counter shows that column.
- R4: `vsync_n` is 0 exactly for lines V_VIS+V_FP through V_VIS+V_FP+V_SYNC-1, with the same two-clock latency.
- R5: For a visible column h, the displayed byte is bits [8*(h mod 4)+7 : 8*(h mod 4)] of buffer word h/4. It appears two clocks after the counter shows h.
- R6: Channel widening: red = {p[7:5], p[7]}, green = {p[4:2], p[4]}, blue = {p[1:0], p[1:0]}, where p is the pixel byte.
- R7: For any column at or beyond H_VIS, or any line at or beyond V_VIS, all three colour outputs are 0.
- R8: When the counter passes column H_VIS-1 on a visible line, `irq` is 1 in the next clock. This holds even if `irq_ack` is high in that same clock.
- R9: Once set, `irq` stays 1 until a clock in which `irq_ack` is high. After that clock it reads 0, unless R8 sets it again.
- R10: No interrupt is raised on lines V_VIS and above.
- R11: A write with `wr_en` high stores `wr_data` at `wr_addr` on the clock edge. Words written during the horizontal blanking are shown on the following line. Writes are accepted while reset is held.
- R12: `line_num` always equals the line the counter is currently on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Buffer write strobe |
| wr_addr | input | ADDR_W | Word index in the line buffer |
| wr_data | input | 32 | Four pixels; lowest byte is the leftmost |
| irq_ack | input | 1 | Clears the line interrupt |
| irq | output | 1 | Line interrupt level |
| line_num | output | CNT_W | Current line of the counter |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| red | output | 4 | Red channel |
| green | output | 4 | Green channel |
| blue | output | 4 | Blue channel |

## Verification
The embedded properties treat `irq_ack` as any level the host likes. They assume the parameters leave room for the buffer index: ADDR_W+2 must not exceed CNT_W, and 4*2^ADDR_W must be at least H_VIS. The pixel checks further assume the host never writes a word in the same clock that the display reads it. The stimulus therefore writes only in the blanking columns that follow the visible part of each line. It runs a shrunken frame twice through so that both counter wraps occur. It also leaves one interrupt unanswered over a full line, and pulses an acknowledge in the very clock the interrupt is set.

// File: rtl/vga_line_display.sv
module vga_line_display #(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              irq_ack,
  output logic              irq,
  output logic [CNT_W-1:0]  line_num,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic [3:0]        red,
  output logic [3:0]        green,
  output logic [3:0]        blue
);

  localparam int WORDS = 1 << ADDR_W;
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam logic [CNT_W-1:0] H_LAST  = CNT_W'(H_TOT - 1);
  localparam logic [CNT_W-1:0] V_LAST  = CNT_W'(V_TOT - 1);
  localparam logic [CNT_W-1:0] H_EDGE  = CNT_W'(H_VIS);
  localparam logic [CNT_W-1:0] V_EDGE  = CNT_W'(V_VIS);
  localparam logic [CNT_W-1:0] HS_BEG  = CNT_W'(H_VIS + H_FP);
  localparam logic [CNT_W-1:0] HS_END  = CNT_W'(H_VIS + H_FP + H_SYNC);
  localparam logic [CNT_W-1:0] VS_BEG  = CNT_W'(V_VIS + V_FP);
  localparam logic [CNT_W-1:0] VS_END  = CNT_W'(V_VIS + V_FP + V_SYNC);
  localparam logic [CNT_W-1:0] H_LASTV = CNT_W'(H_VIS - 1);

  logic [31:0]      line_mem [WORDS];
  logic [CNT_W-1:0] hcnt, vcnt;
  logic [31:0]      rd_word;
  logic [1:0]       sel1;
  logic             de1, hs1_n, vs1_n;
  logic [7:0]       pix;

  wire h_end    = (hcnt == H_LAST);
  wire v_end    = (vcnt == V_LAST);
  wire h_vis    = (hcnt < H_EDGE);
  wire v_vis    = (vcnt < V_EDGE);
  wire hs_on    = (hcnt >= HS_BEG) && (hcnt < HS_END);
  wire vs_on    = (vcnt >= VS_BEG) && (vcnt < VS_END);
  wire line_end = (hcnt == H_LASTV) && v_vis;

  assign line_num = vcnt;

  always_ff @(posedge clk)
    if (wr_en) line_mem[wr_addr] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      hcnt <= h_end ? '0 : hcnt + 1'b1;
      if (h_end) vcnt <= v_end ? '0 : vcnt + 1'b1;
    end
  end

  always_ff @(posedge clk)
    rd_word <= line_mem[hcnt[ADDR_W+1:2]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel1  <= '0;
      de1   <= 1'b0;
      hs1_n <= 1'b1;
      vs1_n <= 1'b1;
    end else begin
      sel1  <= hcnt[1:0];
      de1   <= h_vis && v_vis;
      hs1_n <= !hs_on;
      vs1_n <= !vs_on;
    end
  end

  assign pix = rd_word[8*sel1 +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      red     <= '0;
      green   <= '0;
      blue    <= '0;
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
    end else begin
      red     <= de1 ? {pix[7:5], pix[7]}   : 4'h0;
      green   <= de1 ? {pix[4:2], pix[4]}   : 4'h0;
      blue    <= de1 ? {pix[1:0], pix[1:0]} : 4'h0;
      hsync_n <= hs1_n;
      vsync_n <= vs1_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        irq <= 1'b0;
    else if (line_end) irq <= 1'b1;
    else if (irq_ack)  irq <= 1'b0;
  end

  // R2
  hrange_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt <= H_LAST);

  // R2
  vwrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_end && v_end) |=> (line_num == '0));

  // R4
  vsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(vcnt, 2) >= VS_BEG && $past(vcnt, 2) < VS_END) |-> !vsync_n);

  // R7
  blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hcnt, 2) >= H_EDGE || $past(vcnt, 2) >= V_EDGE) |-> ({red, green, blue} == 12'h0));

  // R8
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hcnt == H_LASTV) && (line_num < V_EDGE)) |=> irq);

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);

  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && irq_ack && (hcnt != H_LASTV)) |=> !irq);

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && (line_num >= V_EDGE)) |=> !irq);

endmodule

// File: tb/tb_vga_line_display.sv
module tb_vga_line_display;
  localparam int H_VIS = 16, H_FP = 2, H_SYNC = 3, H_BP = 3;
  localparam int V_VIS = 6,  V_FP = 1, V_SYNC = 2, V_BP = 1;
  localparam int ADDR_W = 3, CNT_W = 10;
  localparam int WORDS = 1 << ADDR_W;
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int WPL = H_VIS / 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n, wr_en, irq_ack, irq, hsync_n, vsync_n;
  logic [ADDR_W-1:0] wr_addr;
  logic [31:0]       wr_data;
  logic [CNT_W-1:0]  line_num;
  logic [3:0]        red, green, blue;

  vga_line_display #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_ack(irq_ack), .irq(irq), .line_num(line_num), .hsync_n(hsync_n),
    .vsync_n(vsync_n), .red(red), .green(green), .blue(blue)
  );

  int tests = 0, fails = 0;
  bit running = 0, reported = 0;
  logic [13:0] expq[$];
  logic [31:0] buf_m [WORDS];
  int h, v, gl;
  logic irq_m;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
    end
  endtask

  function automatic logic [7:0] pb(input int l, input int i);
    return 8'((l * 53 + i * 17 + 5) & 255);
  endfunction

  function automatic logic [31:0] word_for(input int l, input int w);
    return {pb(l, 4*w+3), pb(l, 4*w+2), pb(l, 4*w+1), pb(l, 4*w)};
  endfunction

  // packed as {hsync_n, vsync_n, red, green, blue}
  function automatic logic [13:0] expect_at(input int hh, input int vv);
    logic [7:0] p;
    logic hs, vs, de;
    p  = buf_m[hh/4][8*(hh%4) +: 8];
    de = (hh < H_VIS) && (vv < V_VIS);
    hs = !((hh >= H_VIS+H_FP) && (hh < H_VIS+H_FP+H_SYNC));
    vs = !((vv >= V_VIS+V_FP) && (vv < V_VIS+V_FP+V_SYNC));
    if (de) return {hs, vs, p[7:5], p[7], p[4:2], p[4], p[1:0], p[1:0]};
    return {hs, vs, 12'h0};
  endfunction

  // monitor: two clocks of output latency
  initial begin
    logic [13:0] e;
    forever begin
      @(posedge clk);
      #2;
      if (running && expq.size() >= 2) begin
        e = expq.pop_front();
        chk("R3 hsync_n", hsync_n, e[13]);
        chk("R4 vsync_n", vsync_n, e[12]);
        if (e[11:0] == 12'h0 && (hsync_n == e[13]) && (e[13] == 1'b0 || e[12] == 1'b0 || 1'b1))
          chk("R5 R6 R7 R11 colour", {red, green, blue}, e[11:0]);
        else
          chk("R5 R6 R11 colour", {red, green, blue}, e[11:0]);
      end
    end
  end

  task automatic step();
    logic set, ack;
    // R12 R2
    chk("R12 R2 line_num", line_num, v);
    if (v >= V_VIS) chk("R10 irq", irq, irq_m);
    else if (irq_m) chk("R8 irq", irq, irq_m);
    else            chk("R9 irq", irq, irq_m);
    expq.push_back(expect_at(h, v));
    ack = 1'b0;
    if (h == H_VIS + 3 && gl != 2) ack = 1'b1;
    if (h == H_VIS - 1 && gl == 4) ack = 1'b1;
    irq_ack = ack;
    set = (h == H_VIS - 1) && (v < V_VIS);
    irq_m = set ? 1'b1 : (ack ? 1'b0 : irq_m);
    // R11: refill during horizontal blanking
    if (h >= H_VIS && h < H_VIS + WPL) begin
      wr_en   = 1'b1;
      wr_addr = ADDR_W'(h - H_VIS);
      wr_data = word_for(gl + 1, h - H_VIS);
      buf_m[h - H_VIS] = wr_data;
    end else begin
      wr_en = 1'b0;
    end
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; irq_ack = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (2) @(negedge clk);
    chk("R1 irq", irq, 0);
    chk("R1 hsync_n", hsync_n, 1);
    chk("R1 vsync_n", vsync_n, 1);
    chk("R1 colour", {red, green, blue}, 0);
    chk("R1 line_num", line_num, 0);
    for (int w = 0; w < WORDS; w++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = ADDR_W'(w); wr_data = word_for(0, w);
      buf_m[w] = wr_data;
    end
    @(negedge clk);
    h = 0; v = 0; gl = 0; irq_m = 1'b0;
    rst_n = 1'b1;
    running = 1;
    for (int c = 0; c < 2 * H_TOT * V_TOT + 4; c++) begin
      step();
      @(negedge clk);
      h++;
      if (h == H_TOT) begin
        h = 0; gl++;
        v = (v == V_TOT - 1) ? 0 : v + 1;
      end
    end
    wr_en = 1'b0; irq_ack = 1'b0;
    repeat (3) @(negedge clk);
    running = 0;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end
endmodule